// File: doc/BRIEF.md
# NAND Command and Address Cycle Sequencer

This block turns one high-level flash request into the ordered list of bus steps that a NAND device expects. A step is a command byte, an address byte or a transfer between the device and one 512-byte area of the controller's page buffer. The steps are handed one at a time to a downstream single-operation engine, which performs the real bus timing and data movement. A request names an operation (page read, spare read, program, erase, status), an optional column, an optional page address and the device geometry: a flag for 2 KB pages (otherwise 512-byte pages) and the capacity in megabytes.

The request port is valid/ready: a request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the sequencer is idle. All request fields and the geometry inputs are sampled in that cycle only. The step port is valid/ready with back-pressure: a step is consumed on a cycle where `step_valid` and `step_ready` are both high, and while `step_ready` is low the offered step stays unchanged. `done` is a plain one-cycle pulse. Operation codes 5 to 7 are reserved and behave as a status request.

Command bytes used: page read 0x00, spare read 0x50, read confirm 0x30, program setup 0x80, program confirm 0x10, erase setup 0x60, erase confirm 0xD0, status 0x70.

Top module: `nand_cycle_seq`

## Requirements
- R1: Step kinds are encoded on `step_kind` as command 0, address 1, data-in (buffer to device) 2, data-out (device to buffer) 3, status read 4; operations on `req_op` are read 0, spare read 1, program 2, erase 3, status 4. After reset `req_ready` is 1 and `step_valid` is 0; while a request is in progress `req_ready` is 0, and a stalled step holds its fields stable.
- R2: `done` pulses for exactly one cycle, in the cycle after the last step of a request is accepted, and is low at all other times (including after reset).
- R3: A read on a 512-byte-page device emits command 0x00, the column byte (column bits 7:0), page bits 7:0, page bits 15:8, page bits 23:16 only when capacity is at least 64 MB, then one data-out transfer into area 0.
- R4: A read on a 2 KB-page device emits command 0x00, the column byte, a second column byte of 0x00, page bits 7:0 and 15:8, page bits 23:16 only when capacity is at least 256 MB, command 0x30, then data-out transfers into areas 0, 1, 2, 3 in that order.
- R5: A spare read on a 512-byte-page device uses command 0x50 in place of 0x00; on a 2 KB-page device it uses 0x00; in both cases every transfer step carries `step_spare` = 1, while plain reads carry 0.
- R6: A program on a 512-byte-page device first emits a pointer command (0x50 when the column is at least 512, otherwise 0x00), then 0x80, the column rebased by subtracting 512 when it was at least 512, the page bytes, one data-in transfer from area 0 (spare flag set when rebased), then 0x10.
- R7: A program on a 2 KB-page device emits 0x80 with no pointer command, the column byte (rebased by 2048 when at least 2048, which also sets the spare flag), 0x00, the page bytes, data-in transfers from areas 0 to 3 in order, then 0x10.
- R8: An erase emits 0x60, the page address bytes with no column even when one is supplied, then 0xD0.
- R9: A status request emits 0x70 followed by a single status-read transfer into area 1, with no address steps.
- R10: Column steps are omitted when no column is supplied (a missing column counts as column 0 for the program pointer choice), and page address steps are omitted when no page is supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 3 | Operation code |
| req_col | input | COL_W | Column offset within the page plus spare |
| req_has_col | input | 1 | Column supplied |
| req_page | input | 24 | Page address |
| req_has_page | input | 1 | Page address supplied |
| cfg_big_page | input | 1 | 1 for 2 KB pages, 0 for 512-byte pages |
| cfg_cap_mb | input | CAP_W | Device capacity in megabytes |
| step_valid | output | 1 | Step offered downstream |
| step_ready | input | 1 | Downstream takes the step |
| step_kind | output | 3 | Step kind |
| step_data | output | 8 | Command or address byte, 0 for transfers |
| step_area | output | 2 | Buffer area of a transfer, 0 otherwise |
| step_spare | output | 1 | Transfer touches the spare area only |
| done | output | 1 | One-cycle pulse after the last step is taken |

## Verification
The bench builds the block with its default parameters: a 12-bit column, a 16-bit capacity field, 512 and 2048-byte page sizes and capacity limits of 64 MB and 256 MB. With these, capacities of 32, 64, 128, 256 and 512 MB land on both sides of each limit, and columns such as 0x205 and 0x803 cross into the spare region so the pointer choice and the rebasing are reached. A pseudo-random `step_ready` pattern stalls the stream at arbitrary points, so every step kind is also seen under back-pressure.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [2:0] OP_READ   = 3'd0;
  localparam logic [2:0] OP_SPARE  = 3'd1;
  localparam logic [2:0] OP_PROG   = 3'd2;
  localparam logic [2:0] OP_ERASE  = 3'd3;
  localparam logic [2:0] OP_STATUS = 3'd4;

  typedef enum logic [2:0] {
    K_CMD  = 3'd0,
    K_ADDR = 3'd1,
    K_DIN  = 3'd2,
    K_DOUT = 3'd3,
    K_STAT = 3'd4
  } kind_e;

  localparam logic [7:0] CODE_READ     = 8'h00;
  localparam logic [7:0] CODE_SPARE    = 8'h50;
  localparam logic [7:0] CODE_CONFIRM  = 8'h30;
  localparam logic [7:0] CODE_SEQIN    = 8'h80;
  localparam logic [7:0] CODE_PROG     = 8'h10;
  localparam logic [7:0] CODE_ERASE    = 8'h60;
  localparam logic [7:0] CODE_ERASE_GO = 8'hD0;
  localparam logic [7:0] CODE_STATUS   = 8'h70;

  localparam int PAGE_W    = 24;
  localparam int STEP_MAX  = 11;
  localparam int IDX_W     = $clog2(STEP_MAX + 1);

  typedef struct packed {
    logic       use_ptr;
    logic [7:0] ptr_code;
    logic [7:0] main_code;
    logic [1:0] col_cnt;
    logic [7:0] col_byte;
    logic [1:0] addr_cnt;
    logic       use_mid;
    logic [7:0] mid_code;
    logic [2:0] xfer_cnt;
    kind_e      xfer_kind;
    logic [1:0] xfer_base;
    logic       spare;
    logic       use_tail;
    logic [7:0] tail_code;
  } plan_t;

endpackage

// File: rtl/nand_seq_decode.sv
module nand_seq_decode
  import nand_seq_pkg::*;
#(
  parameter int COL_W        = 12,
  parameter int CAP_W        = 16,
  parameter int SMALL_PAGE   = 512,
  parameter int BIG_PAGE     = 2048,
  parameter int SMALL_CAP_MB = 64,
  parameter int BIG_CAP_MB   = 256
) (
  input  logic [2:0]       op,
  input  logic [COL_W-1:0] col,
  input  logic             has_col,
  input  logic             has_page,
  input  logic             big,
  input  logic [CAP_W-1:0] cap_mb,
  output plan_t            plan
);

  localparam logic [COL_W-1:0] SMALL_SZ = COL_W'(SMALL_PAGE);
  localparam logic [COL_W-1:0] BIG_SZ   = COL_W'(BIG_PAGE);
  localparam logic [CAP_W-1:0] SMALL_TH = CAP_W'(SMALL_CAP_MB);
  localparam logic [CAP_W-1:0] BIG_TH   = CAP_W'(BIG_CAP_MB);

  logic [COL_W-1:0] col_eff, page_sz, rebased;
  logic             in_spare, deep;
  logic [1:0]       addr_n, col_n;
  logic [2:0]       xfer_n;

  always_comb begin
    col_eff  = has_col ? col : '0;
    page_sz  = big ? BIG_SZ : SMALL_SZ;
    in_spare = (col_eff >= page_sz);
    rebased  = in_spare ? (col_eff - page_sz) : col_eff;
    deep     = big ? (cap_mb >= BIG_TH) : (cap_mb >= SMALL_TH);
    addr_n   = has_page ? (deep ? 2'd3 : 2'd2) : 2'd0;
    col_n    = has_col ? (big ? 2'd2 : 2'd1) : 2'd0;
    xfer_n   = big ? 3'd4 : 3'd1;
  end

  always_comb begin
    plan = '0;
    plan.xfer_kind = K_STAT;
    case (op)
      OP_READ, OP_SPARE: begin
        plan.main_code = (op == OP_SPARE && !big) ? CODE_SPARE : CODE_READ;
        plan.col_cnt   = col_n;
        plan.col_byte  = 8'(col_eff);
        plan.addr_cnt  = addr_n;
        plan.use_mid   = big;
        plan.mid_code  = CODE_CONFIRM;
        plan.xfer_cnt  = xfer_n;
        plan.xfer_kind = K_DOUT;
        plan.spare     = (op == OP_SPARE);
      end
      OP_PROG: begin
        plan.use_ptr   = !big;
        plan.ptr_code  = in_spare ? CODE_SPARE : CODE_READ;
        plan.main_code = CODE_SEQIN;
        plan.col_cnt   = col_n;
        plan.col_byte  = 8'(rebased);
        plan.addr_cnt  = addr_n;
        plan.xfer_cnt  = xfer_n;
        plan.xfer_kind = K_DIN;
        plan.spare     = in_spare;
        plan.use_tail  = 1'b1;
        plan.tail_code = CODE_PROG;
      end
      OP_ERASE: begin
        plan.main_code = CODE_ERASE;
        plan.addr_cnt  = addr_n;
        plan.use_tail  = 1'b1;
        plan.tail_code = CODE_ERASE_GO;
      end
      default: begin
        plan.main_code = CODE_STATUS;
        plan.xfer_cnt  = 3'd1;
        plan.xfer_kind = K_STAT;
        plan.xfer_base = 2'd1;
      end
    endcase
  end

endmodule

// File: rtl/nand_seq_walker.sv
module nand_seq_walker
  import nand_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  plan_t             plan_in,
  input  logic [PAGE_W-1:0] page_in,
  output logic              busy,
  output logic              step_valid,
  input  logic              step_ready,
  output logic [2:0]        step_kind,
  output logic [7:0]        step_data,
  output logic [1:0]        step_area,
  output logic              step_spare,
  output logic              done
);

  plan_t              plan_q;
  logic [PAGE_W-1:0]  page_q;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   o_cmd, o_col, o_addr, o_mid, o_x, o_tail, total;
  logic [IDX_W-1:0]   rel_a, rel_x;
  logic               last;
  kind_e              kind;

  always_comb begin
    o_cmd  = IDX_W'(plan_q.use_ptr);
    o_col  = o_cmd + IDX_W'(1);
    o_addr = o_col + IDX_W'(plan_q.col_cnt);
    o_mid  = o_addr + IDX_W'(plan_q.addr_cnt);
    o_x    = o_mid + IDX_W'(plan_q.use_mid);
    o_tail = o_x + IDX_W'(plan_q.xfer_cnt);
    total  = o_tail + IDX_W'(plan_q.use_tail);
    last   = (idx == total - IDX_W'(1));
    rel_a  = idx - o_addr;
    rel_x  = idx - o_x;
  end

  always_comb begin
    kind       = K_CMD;
    step_data  = 8'h00;
    step_area  = 2'd0;
    step_spare = 1'b0;
    if (idx < o_cmd) begin
      step_data = plan_q.ptr_code;
    end else if (idx < o_col) begin
      step_data = plan_q.main_code;
    end else if (idx < o_addr) begin
      kind      = K_ADDR;
      step_data = (idx == o_col) ? plan_q.col_byte : 8'h00;
    end else if (idx < o_mid) begin
      kind = K_ADDR;
      case (rel_a)
        IDX_W'(0): step_data = page_q[7:0];
        IDX_W'(1): step_data = page_q[15:8];
        default:   step_data = page_q[23:16];
      endcase
    end else if (idx < o_x) begin
      step_data = plan_q.mid_code;
    end else if (idx < o_tail) begin
      kind       = plan_q.xfer_kind;
      step_spare = plan_q.spare;
      case (rel_x)
        IDX_W'(1): step_area = plan_q.xfer_base + 2'd1;
        IDX_W'(2): step_area = plan_q.xfer_base + 2'd2;
        IDX_W'(3): step_area = plan_q.xfer_base + 2'd3;
        default:   step_area = plan_q.xfer_base;
      endcase
    end else begin
      step_data = plan_q.tail_code;
    end
  end

  assign step_kind  = kind;
  assign step_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      done   <= 1'b0;
      plan_q <= '0;
      page_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          idx    <= '0;
          plan_q <= plan_in;
          page_q <= page_in;
        end
      end else if (step_ready) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  // R1: an offered step that is not taken stays put
  a_r1_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !step_ready |=> step_valid && $stable(step_kind)
      && $stable(step_data) && $stable(step_area) && $stable(step_spare));

  // R1: every sequence opens with a command step
  a_r1_first_is_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_valid) |-> step_kind == K_CMD);

  // R2: done lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: done only follows an accepted step that ended the sequence
  a_r2_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(step_valid && step_ready) && !step_valid);

  // R9: status reads always land in area 1
  a_r9_status_area: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && step_kind == K_STAT |-> step_area == 2'd1);

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int COL_W        = 12,
  parameter int CAP_W        = 16,
  parameter int SMALL_PAGE   = 512,
  parameter int BIG_PAGE     = 2048,
  parameter int SMALL_CAP_MB = 64,
  parameter int BIG_CAP_MB   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_has_col,
  input  logic [23:0]       req_page,
  input  logic              req_has_page,
  input  logic              cfg_big_page,
  input  logic [CAP_W-1:0]  cfg_cap_mb,
  output logic              step_valid,
  input  logic              step_ready,
  output logic [2:0]        step_kind,
  output logic [7:0]        step_data,
  output logic [1:0]        step_area,
  output logic              step_spare,
  output logic              done
);

  plan_t plan;
  logic  busy;
  logic  start;

  nand_seq_decode #(
    .COL_W(COL_W), .CAP_W(CAP_W), .SMALL_PAGE(SMALL_PAGE),
    .BIG_PAGE(BIG_PAGE), .SMALL_CAP_MB(SMALL_CAP_MB), .BIG_CAP_MB(BIG_CAP_MB)
  ) u_decode (
    .op(req_op), .col(req_col), .has_col(req_has_col),
    .has_page(req_has_page), .big(cfg_big_page), .cap_mb(cfg_cap_mb),
    .plan(plan)
  );

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  nand_seq_walker u_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .plan_in(plan),
    .page_in(req_page), .busy(busy), .step_valid(step_valid),
    .step_ready(step_ready), .step_kind(step_kind), .step_data(step_data),
    .step_area(step_area), .step_spare(step_spare), .done(done)
  );

  // R1: a taken request starts a step stream on the next cycle
  a_r1_start_offers: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> step_valid && !req_ready);

endmodule

// File: tb/nand_cycle_seq_test.sv
module nand_cycle_seq_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [11:0] req_col = '0;
  logic        req_has_col = 1'b0;
  logic [23:0] req_page = '0;
  logic        req_has_page = 1'b0;
  logic        cfg_big_page = 1'b0;
  logic [15:0] cfg_cap_mb = '0;
  logic        step_valid;
  logic        step_ready = 1'b0;
  logic [2:0]  step_kind;
  logic [7:0]  step_data;
  logic [1:0]  step_area;
  logic        step_spare;
  logic        done;

  nand_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_col(req_col), .req_has_col(req_has_col),
    .req_page(req_page), .req_has_page(req_has_page),
    .cfg_big_page(cfg_big_page), .cfg_cap_mb(cfg_cap_mb),
    .step_valid(step_valid), .step_ready(step_ready), .step_kind(step_kind),
    .step_data(step_data), .step_area(step_area), .step_spare(step_spare),
    .done(done)
  );

  always #(CLK_NS/2) clk = ~clk;

  int          vectors = 0;
  int          fails = 0;
  bit          finished = 1'b0;
  bit          pend_done = 1'b0;
  logic [7:0]  lfsr = 8'h5B;
  string       cur_tag = "R1";
  logic [13:0] sb[$];

  // expected item: {kind[2:0], data[7:0], area[1:0], spare}
  task automatic put(input logic [2:0] k, input logic [7:0] d,
                     input logic [1:0] a, input logic s);
    sb.push_back({k, d, a, s});
  endtask

  task automatic model(input logic [2:0] op, input logic [11:0] col,
                       input bit hc, input logic [23:0] page, input bit hp,
                       input bit big, input int cap);
    int an;
    int ce;
    int psz;
    bit sp;
    int rb;
    an  = big ? ((cap >= 256) ? 3 : 2) : ((cap >= 64) ? 3 : 2);
    ce  = hc ? int'(col) : 0;
    psz = big ? 2048 : 512;
    sp  = (ce >= psz);
    rb  = sp ? ce - psz : ce;
    case (op)
      3'd0, 3'd1: begin
        put(3'd0, (op == 3'd1 && !big) ? 8'h50 : 8'h00, 2'd0, 1'b0);
        if (hc) begin
          put(3'd1, col[7:0], 2'd0, 1'b0);
          if (big) put(3'd1, 8'h00, 2'd0, 1'b0);
        end
        if (hp) for (int b = 0; b < an; b++) put(3'd1, page[8*b +: 8], 2'd0, 1'b0);
        if (big) put(3'd0, 8'h30, 2'd0, 1'b0);
        for (int a = 0; a < (big ? 4 : 1); a++) put(3'd3, 8'h00, 2'(a), op == 3'd1);
      end
      3'd2: begin
        if (!big) put(3'd0, sp ? 8'h50 : 8'h00, 2'd0, 1'b0);
        put(3'd0, 8'h80, 2'd0, 1'b0);
        if (hc) begin
          put(3'd1, 8'(rb), 2'd0, 1'b0);
          if (big) put(3'd1, 8'h00, 2'd0, 1'b0);
        end
        if (hp) for (int b = 0; b < an; b++) put(3'd1, page[8*b +: 8], 2'd0, 1'b0);
        for (int a = 0; a < (big ? 4 : 1); a++) put(3'd2, 8'h00, 2'(a), sp);
        put(3'd0, 8'h10, 2'd0, 1'b0);
      end
      3'd3: begin
        put(3'd0, 8'h60, 2'd0, 1'b0);
        if (hp) for (int b = 0; b < an; b++) put(3'd1, page[8*b +: 8], 2'd0, 1'b0);
        put(3'd0, 8'hD0, 2'd0, 1'b0);
      end
      default: begin
        put(3'd0, 8'h70, 2'd0, 1'b0);
        put(3'd4, 8'h00, 2'd1, 1'b0);
      end
    endcase
  endtask

  // monitor: ready pattern, step compare, done check
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step_ready = lfsr[0] | lfsr[2];
      if (pend_done) begin
        vectors++;
        pend_done = 1'b0;
        if (done !== 1'b1) begin
          fails++;
          $display("FAIL R2 (%s) done after last step: got %b expected 1", cur_tag, done);
        end
      end else if (done !== 1'b0) begin
        vectors++;
        fails++;
        $display("FAIL R2 (%s) unexpected done: got %b expected 0", cur_tag, done);
      end
      if (step_valid && step_ready) begin
        vectors++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL %s extra step: got kind %0d data %h expected none",
                   cur_tag, step_kind, step_data);
        end else begin
          logic [13:0] exp;
          exp = sb.pop_front();
          if ({step_kind, step_data, step_area, step_spare} !== exp) begin
            fails++;
            $display("FAIL %s step: got kind %0d data %h area %0d spare %b expected kind %0d data %h area %0d spare %b",
                     cur_tag, step_kind, step_data, step_area, step_spare,
                     exp[13:11], exp[10:3], exp[2:1], exp[0]);
          end
          if (sb.size() == 0) pend_done = 1'b1;
        end
      end
    end
  end

  task automatic send(input string tag, input logic [2:0] op,
                      input logic [11:0] col, input bit hc,
                      input logic [23:0] page, input bit hp,
                      input bit big, input int cap);
    do @(negedge clk); while (!req_ready);
    cur_tag = tag;
    model(op, col, hc, page, hp, big, cap);
    req_op = op; req_col = col; req_has_col = hc; req_page = page;
    req_has_page = hp; cfg_big_page = big; cfg_cap_mb = 16'(cap);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_op = 3'd7; req_col = '1; req_page = '1; cfg_cap_mb = '0;
    vectors++;
    if (req_ready !== 1'b0) begin
      fails++;
      $display("FAIL R1 (%s) req_ready while busy: got %b expected 0", tag, req_ready);
    end
    while (sb.size() != 0 || pend_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if (req_ready !== 1'b1 || step_valid !== 1'b0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state: got ready %b valid %b done %b expected 1 0 0",
               req_ready, step_valid, done);
    end
    send("R3", 3'd0, 12'h1A5, 1, 24'hABCDEF, 1, 0, 32);
    send("R3", 3'd0, 12'h0C3, 1, 24'h123456, 1, 0, 64);
    send("R4", 3'd0, 12'h7FF, 1, 24'h89ABCD, 1, 1, 128);
    send("R4", 3'd0, 12'h044, 1, 24'h5A5A5A, 1, 1, 256);
    send("R5", 3'd1, 12'h00F, 1, 24'h010203, 1, 0, 128);
    send("R5", 3'd1, 12'h802, 1, 24'h0A0B0C, 1, 1, 512);
    send("R6", 3'd2, 12'h010, 1, 24'h334455, 1, 0, 64);
    send("R6", 3'd2, 12'h205, 1, 24'h667788, 1, 0, 32);
    send("R7", 3'd2, 12'h803, 1, 24'hC0FFEE, 1, 1, 256);
    send("R7", 3'd2, 12'h1F0, 1, 24'h000102, 1, 1, 64);
    send("R8", 3'd3, 12'h000, 0, 24'h00FF40, 1, 0, 64);
    send("R8", 3'd3, 12'h155, 1, 24'h13579B, 1, 1, 512);
    send("R9", 3'd4, 12'h155, 1, 24'hFFFFFF, 1, 1, 512);
    send("R9", 3'd4, 12'h000, 0, 24'h000000, 0, 0, 32);
    send("R10", 3'd0, 12'h0AA, 0, 24'h000000, 0, 0, 64);
    send("R10", 3'd0, 12'h0AA, 0, 24'h246801, 1, 1, 128);
    send("R10", 3'd2, 12'h300, 0, 24'h112233, 1, 0, 32);
    send("R2", 3'd4, 12'h000, 0, 24'h0, 0, 0, 32);
    send("R2", 3'd4, 12'h000, 0, 24'h0, 0, 1, 32);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule